// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns bytes into asynchronous serial frames on a single line. A line-control byte sets the whole frame: the word length (5 to 8 bits), whether a parity bit follows the data, whether that bit is computed (even or odd) or held at a fixed level, and whether one, one and a half, or two stop bits close the frame. Bytes enter through a valid/ready handshake into a single holding slot. From there they move into a shifter, so the host can post the next byte while the current one is still on the wire.

Bit timing comes from an oversampling enable pulse that a divisor block outside this one supplies. Each bit lasts `OVERSAMPLE` pulses. The fractional stop length is one and a half times that count. A break control forces the line low at once, whatever the shifter is doing. An optional clear-to-send gate holds back the start of a new character until the far end is ready. Two status flags report whether the holding slot is free and whether the transmitter as a whole is idle.

Top module: `txf_serial_tx`

## Requirements
- R1: Out of reset, and whenever nothing is being sent and break is off, `txd` is high (mark). `thr_empty`, `tx_empty` and `in_ready` are all 1 out of reset.
- R2: A frame starts with one low start bit of `OVERSAMPLE` ticks. The data bits follow, least significant first, each `OVERSAMPLE` ticks long. The count is set by `line_ctl[1:0]`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. A frame starts only on a `tick` cycle.
- R3: With `line_ctl[2]`=0 the stop part is high for `OVERSAMPLE` ticks. With `line_ctl[2]`=1 it is high for 1.5×`OVERSAMPLE` ticks on 5-bit words and for 2×`OVERSAMPLE` ticks on 6, 7 and 8-bit words.
- R4: With `line_ctl[3]`=1 and `line_ctl[5]`=0, one parity bit of `OVERSAMPLE` ticks sits between the last data bit and the stop part. `line_ctl[4]`=1 makes the total count of ones over data and parity even. `line_ctl[4]`=0 makes it odd. With `line_ctl[3]`=0 there is no parity bit.
- R5: With `line_ctl[3]`=1 and `line_ctl[5]`=1, the parity bit is constant: 0 when `line_ctl[4]`=1 and 1 when `line_ctl[4]`=0.
- R6: While `line_ctl[6]`=1, `txd` is low in the same cycle, even in the middle of a character. The character keeps its timing underneath, and the line shows the rest of it once the bit clears.
- R7: `in_ready` and `thr_empty` are 1 exactly when the holding slot is free. A byte is accepted on a clock with `in_valid` and `in_ready` both high. The slot frees as its byte moves into the shifter, while that character is still being sent.
- R8: `tx_empty` is 1 only when the holding slot is free and no frame is in progress.
- R9: With `cts_gate_en`=1, a new frame does not start while `cts`=0. With `cts_gate_en`=0, `cts` has no effect.
- R10: A waiting byte starts on the same tick that ends the previous stop part, with no idle gap. The frame settings are taken at the start of each frame, so changing `line_ctl[5:0]` mid-frame does not alter the character in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, one pulse per sub-bit period |
| line_ctl | input | 8 | Line-control byte (bit 7 unused) |
| cts_gate_en | input | 1 | Make new frames wait for `cts` |
| cts | input | 1 | Clear-to-send from the far end, active high |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send (upper bits unused for short words) |
| in_ready | output | 1 | Holding slot can take a byte |
| txd | output | 1 | Serial line, idle high |
| thr_empty | output | 1 | Holding slot free |
| tx_empty | output | 1 | Holding slot free and shifter idle |

## Verification
A wrong shift count, bit index or stop length shows on `txd` within one bit period of the faulty step. It appears as an edge that is early or late against the reference level stream, and the bench compares that stream on every clock. A stuck or mis-cleared holding flag shows at once on `in_ready` and `thr_empty`. It also shows within one tick as a frame that starts when it should not, or fails to start when it should, and so skews every later level. Parity and stick-parity faults show only in the one bit period that carries the parity bit. The bench therefore runs every parity mode against data patterns with odd and even weights.

// File: rtl/txf_pkg.sv
package txf_pkg;

   localparam int unsigned DW = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } txf_state_e;

   typedef struct packed {
      logic [1:0] wsel;
      logic       long_stop;
      logic       par_en;
      logic       par_even;
      logic       par_stick;
      logic       brk;
   } txf_lc_t;

   function automatic txf_lc_t lc_decode(input logic [7:0] lc);
      txf_lc_t r;
      r.wsel      = lc[1:0];
      r.long_stop = lc[2];
      r.par_en    = lc[3];
      r.par_even  = lc[4];
      r.par_stick = lc[5];
      r.brk       = lc[6];
      return r;
   endfunction

endpackage

// File: rtl/txf_hold.sv
module txf_hold
   import txf_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          take,
   output logic          in_ready,
   output logic          full,
   output logic [DW-1:0] data
);

   assign in_ready = ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (in_valid && !full) begin
         full <= 1'b1;
         data <= in_data;
      end
   end

   // R7: an accepted byte occupies the slot on the next cycle
   p_accept_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> full);

   // R7: a held byte is not overwritten while waiting
   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && $past(full)) |-> $stable(data));

endmodule

// File: rtl/txf_frame_cfg.sv
module txf_frame_cfg
   import txf_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned CNT_W      = $clog2(2*OVERSAMPLE)
)(
   input  logic [7:0]       lc,
   input  logic [DW-1:0]    data,
   output logic             par_en,
   output logic             par_bit,
   output logic [2:0]       last_idx,
   output logic [CNT_W-1:0] stop_last
);

   localparam int unsigned ONE_STOP  = OVERSAMPLE;
   localparam int unsigned HALF_STOP = OVERSAMPLE + OVERSAMPLE/2;
   localparam int unsigned TWO_STOP  = 2*OVERSAMPLE;

   txf_lc_t       f;
   logic [DW-1:0] mask;
   logic          ones_odd;

   assign f = lc_decode(lc);

   always_comb begin
      last_idx = 3'd4 + {1'b0, f.wsel};
      mask     = '0;
      for (int i = 0; i < DW; i++) begin
         if (i <= int'(last_idx)) mask[i] = 1'b1;
      end
      ones_odd = ^(data & mask);
      par_en   = f.par_en;
      if (f.par_stick)     par_bit = ~f.par_even;
      else if (f.par_even) par_bit = ones_odd;
      else                 par_bit = ~ones_odd;

      if (!f.long_stop)        stop_last = CNT_W'(ONE_STOP - 1);
      else if (f.wsel == 2'b00) stop_last = CNT_W'(HALF_STOP - 1);
      else                     stop_last = CNT_W'(TWO_STOP - 1);
   end

endmodule

// File: rtl/txf_shifter.sv
module txf_shifter
   import txf_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned CNT_W      = $clog2(2*OVERSAMPLE)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start_req,
   input  logic [DW-1:0]    ld_data,
   input  logic             ld_par_en,
   input  logic             ld_par_bit,
   input  logic [2:0]       ld_last_idx,
   input  logic [CNT_W-1:0] ld_stop_last,
   output logic             take,
   output logic             busy,
   output logic             line
);

   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

   txf_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       idx;
   logic [DW-1:0]    sh;
   logic             par_q;
   logic             pen_q;
   logic [2:0]       last_q;
   logic [CNT_W-1:0] stop_q;
   logic             stop_end;

   assign stop_end = (state == ST_STOP) && (cnt == stop_q);
   assign take     = tick && start_req && ((state == ST_IDLE) || stop_end);
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         idx    <= '0;
         sh     <= '0;
         par_q  <= 1'b1;
         pen_q  <= 1'b0;
         last_q <= '0;
         stop_q <= '0;
      end else if (take) begin
         state  <= ST_START;
         cnt    <= '0;
         idx    <= '0;
         sh     <= ld_data;
         par_q  <= ld_par_bit;
         pen_q  <= ld_par_en;
         last_q <= ld_last_idx;
         stop_q <= ld_stop_last;
      end else if (tick) begin
         case (state)
            ST_START: begin
               if (cnt == BIT_LAST) begin
                  state <= ST_DATA;
                  cnt   <= '0;
                  idx   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            ST_DATA: begin
               if (cnt == BIT_LAST) begin
                  cnt <= '0;
                  sh  <= sh >> 1;
                  if (idx == last_q) state <= pen_q ? ST_PAR : ST_STOP;
                  else idx <= idx + 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            ST_PAR: begin
               if (cnt == BIT_LAST) begin
                  state <= ST_STOP;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            ST_STOP: begin
               if (stop_end) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            default: cnt <= '0;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_START: line = 1'b0;
         ST_DATA:  line = sh[0];
         ST_PAR:   line = par_q;
         default:  line = 1'b1;
      endcase
   end

   // R2: nothing advances between oversampling pulses
   p_tick_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(state) && $stable(cnt)));

   // R3: outside the stop part a bit never runs past one bit period
   p_bit_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_STOP) |-> (cnt <= BIT_LAST));

   // R4: the parity slot is entered only from the last data bit with parity on
   p_par_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_PAR) |-> ($past(state) == ST_DATA && pen_q));

endmodule

// File: rtl/txf_serial_tx.sv
module txf_serial_tx
   import txf_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter bit          REG_OUT    = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [7:0]    line_ctl,
   input  logic          cts_gate_en,
   input  logic          cts,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          in_ready,
   output logic          txd,
   output logic          thr_empty,
   output logic          tx_empty
);

   localparam int unsigned CNT_W = $clog2(2*OVERSAMPLE);

   initial begin
      assert (OVERSAMPLE >= 4 && (OVERSAMPLE % 2) == 0)
         else $error("OVERSAMPLE must be even and at least 4");
   end

   logic             hold_full, take, busy, line_raw, line_out, start_req;
   logic [DW-1:0]    hold_data;
   logic             c_par_en, c_par_bit;
   logic [2:0]       c_last_idx;
   logic [CNT_W-1:0] c_stop_last;

   assign start_req = hold_full && (!cts_gate_en || cts);

   txf_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .take     (take),
      .in_ready (in_ready),
      .full     (hold_full),
      .data     (hold_data)
   );

   txf_frame_cfg #(.OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_cfg (
      .lc        (line_ctl),
      .data      (hold_data),
      .par_en    (c_par_en),
      .par_bit   (c_par_bit),
      .last_idx  (c_last_idx),
      .stop_last (c_stop_last)
   );

   txf_shifter #(.OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .start_req    (start_req),
      .ld_data      (hold_data),
      .ld_par_en    (c_par_en),
      .ld_par_bit   (c_par_bit),
      .ld_last_idx  (c_last_idx),
      .ld_stop_last (c_stop_last),
      .take         (take),
      .busy         (busy),
      .line         (line_raw)
   );

   assign line_out  = line_ctl[6] ? 1'b0 : line_raw;
   assign thr_empty = ~hold_full;
   assign tx_empty  = ~hold_full & ~busy;

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) txd <= 1'b1;
            else        txd <= line_out;
         end
      end else begin : g_comb_out
         assign txd = line_out;

         // R1: an idle transmitter without break holds the line at mark
         p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_empty && !line_ctl[6]) |-> txd);
      end
   endgenerate

   // R8: whole-transmitter empty implies the holding slot is empty
   p_temt_thre_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> thr_empty);

   // R9: the slot is drained only when the clear-to-send gate allowed it
   p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(thr_empty) && !$past(in_valid && in_ready)) |->
         $past(!cts_gate_en || cts));

   // R2: a frame starts only on an oversampling pulse
   p_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_empty) |-> $past(tick));

endmodule

// File: tb/txf_serial_tx_test.sv
module txf_serial_tx_test;

   localparam int OS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] line_ctl = 8'h03;
   logic       cts_gate_en = 1'b0;
   logic       cts = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready, txd, thr_empty, tx_empty;

   int    nchk = 0;
   int    nfail = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   always #2.5 clk = ~clk;

   txf_serial_tx #(.OVERSAMPLE(OS)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_ctl(line_ctl),
      .cts_gate_en(cts_gate_en), .cts(cts), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .txd(txd),
      .thr_empty(thr_empty), .tx_empty(tx_empty)
   );

   // Tick pattern: one pulse every third clock
   int cyc = 0;
   always @(posedge clk) begin
      #1;
      cyc = cyc + 1;
      tick = (cyc % 3 == 0);
   end

   // Reference model: a queue of line levels, one per tick
   bit       q[$];
   bit       m_full = 1'b0;
   bit [7:0] m_data = 8'h00;

   task automatic push_frame(input bit [7:0] d, input bit [7:0] lc);
      int nb, stop;
      bit ones, p;
      nb = 5 + int'(lc[1:0]);
      for (int k = 0; k < OS; k++) q.push_back(1'b0);
      ones = 1'b0;
      for (int b = 0; b < nb; b++) begin
         ones = ones ^ d[b];
         for (int k = 0; k < OS; k++) q.push_back(d[b]);
      end
      if (lc[3]) begin
         if (lc[5]) p = ~lc[4];
         else       p = lc[4] ? ones : ~ones;
         for (int k = 0; k < OS; k++) q.push_back(p);
      end
      if (!lc[2])      stop = OS;
      else if (nb == 5) stop = OS + OS/2;
      else             stop = 2*OS;
      for (int k = 0; k < stop; k++) q.push_back(1'b1);
   endtask

   always @(posedge clk) begin
      bit ready_pre;
      if (!rst_n) begin
         q.delete();
         m_full = 1'b0;
      end else begin
         ready_pre = !m_full;
         if (tick) begin
            if (q.size() > 0) void'(q.pop_front());
            if (q.size() == 0 && m_full && (!cts_gate_en || cts)) begin
               push_frame(m_data, line_ctl);
               m_full = 1'b0;
            end
         end
         if (in_valid && ready_pre) begin
            m_full = 1'b1;
            m_data = in_data;
         end
      end
   end

   // Per-cycle comparison on the falling edge
   always @(negedge clk) begin
      bit e_txd, e_thre, e_temt;
      if (rst_n && !finished) begin
         e_txd  = line_ctl[6] ? 1'b0 : (q.size() > 0 ? q[0] : 1'b1);
         e_thre = !m_full;
         e_temt = !m_full && (q.size() == 0);
         nchk++;
         if (txd !== e_txd || thr_empty !== e_thre || tx_empty !== e_temt ||
             in_ready !== e_thre) begin
            nfail++;
            $display("FAIL %s: txd/thre/temt/ready = %b%b%b%b, expected %b%b%b%b",
                     cur_tag, txd, thr_empty, tx_empty, in_ready,
                     e_txd, e_thre, e_temt, e_thre);
         end
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %b, expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send(input bit [7:0] d);
      step(1);
      while (!in_ready) step(1);
      in_valid = 1'b1;
      in_data  = d;
      step(1);
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      step(1);
      while (!tx_empty) step(1);
      step(4);
   endtask

   task automatic frame(input string tag, input bit [7:0] lc, input bit [7:0] d);
      cur_tag  = tag;
      line_ctl = lc;
      send(d);
      wait_idle();
   endtask

   initial begin
      step(5);
      #1.5;
      cur_tag = "R1";
      check("R1 reset txd", txd, 1'b1);
      check("R1 reset thr_empty", thr_empty, 1'b1);
      check("R1 reset tx_empty", tx_empty, 1'b1);
      check("R1 reset in_ready", in_ready, 1'b1);
      step(1);
      rst_n = 1'b1;
      step(10);

      // R2: word lengths, LSB first
      frame("R2", 8'h03, 8'hA5);
      frame("R2", 8'h00, 8'h16);
      frame("R2", 8'h01, 8'h2D);
      frame("R2", 8'h02, 8'h4E);
      // R3: stop lengths
      frame("R3", 8'h04, 8'h13);
      frame("R3", 8'h06, 8'h55);
      frame("R3", 8'h07, 8'hF0);
      // R4: computed parity
      frame("R4", 8'h1B, 8'h07);
      frame("R4", 8'h0B, 8'h07);
      frame("R4", 8'h1B, 8'h0F);
      frame("R4", 8'h08, 8'h09);
      // R5: stick parity
      frame("R5", 8'h2B, 8'h00);
      frame("R5", 8'h3B, 8'hFF);

      // R6: break in the middle of a character
      cur_tag  = "R6";
      line_ctl = 8'h03;
      send(8'hFF);
      step(100);
      line_ctl = 8'h43;
      #1.5;
      check("R6 break low", txd, 1'b0);
      step(60);
      line_ctl = 8'h03;
      wait_idle();

      // R7/R8/R10: back-to-back bytes and mid-frame config change
      cur_tag = "R7";
      send(8'h3C);
      step(1);
      while (!thr_empty) step(1);
      step(3);
      check("R7 slot free while shifting", thr_empty, 1'b1);
      check("R8 not empty while shifting", tx_empty, 1'b0);
      cur_tag = "R10";
      send(8'hC3);
      line_ctl = 8'h1F;
      step(90);
      line_ctl = 8'h03;
      wait_idle();

      // R9: clear-to-send gating
      cur_tag     = "R9";
      cts_gate_en = 1'b1;
      cts         = 1'b0;
      send(8'h81);
      step(200);
      #1.5;
      check("R9 gated line idle", txd, 1'b1);
      check("R9 gated byte held", thr_empty, 1'b0);
      step(1);
      cts = 1'b1;
      step(8);
      check("R9 start after cts", tx_empty, 1'b0);
      wait_idle();
      cts_gate_en = 1'b0;
      cts         = 1'b0;
      frame("R9", 8'h03, 8'h42);

      step(10);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

endmodule